// File: doc/BRIEF.md
# Shared Memory Bank Conflict Resolver

This block takes one warp-wide access to a banked scratchpad and decides how it is spread over time. Every lane carries a byte address. The block turns each address into a 4-byte slot index and a bank index. It then splits the request into passes so that no bank serves two different slots in the same cycle.

The block emits one lane-grant mask per cycle. A downstream SRAM stage uses these masks to steer lanes onto the bank ports. Reads of the same slot share a single bank access by broadcast. Writes are never merged, so lanes that write the same slot go one at a time, lowest lane first. The block keeps no data. It only schedules.

A request enters through a valid/ready handshake and carries an active-lane mask and a read/write flag. The last grant of a request raises a completion flag together with the total pass count. A request with no active lanes completes at once and reports zero passes.

Top module: `bank_conflict_resolver`

## Requirements
- R1: A lane's slot is its byte address divided by 4, rounded down. Its bank is that slot modulo 32. Byte address 70 falls in slot 17 and bank 17, and so does byte address 198 (slot 49). Byte addresses 0 and 128 both fall in bank 0.
- R2: `req_ready` is 1 while the block is idle. A request is taken on a rising edge where both `req_valid` and `req_ready` are 1. `req_ready` then stays 0 until the edge that follows the cycle with `done` high.
- R3: If every active lane maps to a different bank, the request takes exactly one pass, and that pass grants the whole active mask.
- R4: If all active lanes read the same slot, the request takes one pass by broadcast.
- R5: For a read, each pass serves one slot per bank and grants every pending lane that reads that slot. The number of passes equals the largest count of distinct slots within any single bank.
- R6: Within a bank, the slot served next is the one named by the lowest-numbered lane still pending.
- R7: For a write (`req_write`=1), each pass grants at most one lane per bank: the lowest-numbered pending lane of that bank. Lanes that write the same slot therefore get separate passes in ascending lane order.
- R8: A lane outside the active mask is never granted. Every active lane is granted exactly once per request.
- R9: Passes come out one per cycle with `gnt_valid`=1 and a nonempty `gnt_mask`. The first pass appears in the cycle after acceptance, and the passes follow in consecutive cycles.
- R10: `done` is 1 in the cycle of the final pass. In that cycle `pass_count` equals the number of passes issued, counting the final one.
- R11: A request with an all-zero active mask issues no grant. In the cycle after acceptance it shows `done`=1 and `pass_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, can take a request |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_active | input | 32 | Active-lane mask, bit i = lane i |
| req_addr | input | 512 | Lane byte addresses, lane i at bits [16i+15:16i] |
| gnt_valid | output | 1 | A pass is presented this cycle |
| gnt_mask | output | 32 | Lanes served in this pass |
| done | output | 1 | Final cycle of the request |
| pass_count | output | 6 | Total number of passes, valid while done is 1 |

## Verification
The first grant mask is due in the cycle after the accepting edge, because the request passes through one register on the way. Each later pass is due one cycle after the one before it. `done` and `pass_count` come with the final pass, or one cycle after acceptance for an empty request. `req_ready` returns one cycle after `done`. The bench drives inputs on the falling edge and applies each request on the next rising edge. On every following falling edge it compares the outputs with the next pass produced by its own per-bank scheduling model. Each comparison therefore lands in exactly the cycle where that result is due.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_EMPTY = 2'd2
  } bcr_state_e;
endpackage

// File: rtl/bcr_bank_map.sv
// Per-lane address decode: slot index (address / slot size) and bank index.
module bcr_bank_map #(
  parameter int LANES   = 32,
  parameter int ADDR_W  = 16,
  parameter int SLOT_SH = 2,
  parameter int BANK_W  = 5,
  localparam int WORD_W = ADDR_W - SLOT_SH
) (
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  output logic [LANES*WORD_W-1:0] word_flat,
  output logic [LANES*BANK_W-1:0] bank_flat
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] a;
    assign a = addr_flat[l*ADDR_W +: ADDR_W];
    assign word_flat[l*WORD_W +: WORD_W] = a[ADDR_W-1:SLOT_SH];
    // bank count is a power of two: modulo is the low slot bits
    assign bank_flat[l*BANK_W +: BANK_W] = a[SLOT_SH +: BANK_W];
  end
endmodule

// File: rtl/bcr_pass_select.sv
// Combinational choice of the lanes served in the current pass.
module bcr_pass_select #(
  parameter int LANES  = 32,
  parameter int WORD_W = 14,
  parameter int BANK_W = 5
) (
  input  logic [LANES-1:0]        pending,
  input  logic                    is_write,
  input  logic [LANES*WORD_W-1:0] word_flat,
  input  logic [LANES*BANK_W-1:0] bank_flat,
  output logic [LANES-1:0]        grant
);
  logic [WORD_W-1:0] word_a [LANES];
  logic [BANK_W-1:0] bank_a [LANES];
  logic [LANES-1:0]  leader;

  for (genvar l = 0; l < LANES; l++) begin : g_unpack
    assign word_a[l] = word_flat[l*WORD_W +: WORD_W];
    assign bank_a[l] = bank_flat[l*BANK_W +: BANK_W];
  end

  // leader: lowest pending lane of its bank
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic lower_hit;
      lower_hit = 1'b0;
      for (int k = 0; k < i; k++) begin
        if (pending[k] && (bank_a[k] == bank_a[i])) lower_hit = 1'b1;
      end
      leader[i] = pending[i] & ~lower_hit;
    end
  end

  // reads: every pending lane sharing a leader's slot; writes: leaders only
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      logic share;
      share = 1'b0;
      for (int i = 0; i < LANES; i++) begin
        if (leader[i] && (word_a[i] == word_a[j])) share = 1'b1;
      end
      grant[j] = is_write ? leader[j] : (pending[j] & share);
    end
  end
endmodule

// File: rtl/bcr_pass_ctrl.sv
// Request sequencing: pending lanes, pass counter, completion.
module bcr_pass_ctrl
  import bcr_pkg::*;
#(
  parameter int LANES = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LANES-1:0] req_active,
  input  logic [LANES-1:0] grant,
  output logic             accept,
  output logic             req_ready,
  output logic [LANES-1:0] pending,
  output logic             gnt_valid,
  output logic             done,
  output logic [CNT_W-1:0] pass_count
);
  bcr_state_e       state_q, state_d;
  logic [LANES-1:0] pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LANES-1:0] remain;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready & req_valid;
  assign remain    = pend_q & ~grant;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          pend_d  = req_active;
          cnt_d   = '0;
          state_d = (req_active == '0) ? ST_EMPTY : ST_BUSY;
        end
      end
      ST_BUSY: begin
        pend_d = remain;
        cnt_d  = cnt_q + 1'b1;
        if (remain == '0) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pending    = pend_q;
  assign gnt_valid  = (state_q == ST_BUSY);
  assign done       = (state_q == ST_EMPTY) | (gnt_valid & (remain == '0));
  assign pass_count = (gnt_valid && remain == '0) ? cnt_q + 1'b1 : '0;
endmodule

// File: rtl/bank_conflict_resolver.sv
module bank_conflict_resolver #(
  parameter int LANES      = 32,
  parameter int NBANKS     = 32,
  parameter int SLOT_BYTES = 4,
  parameter int ADDR_W     = 16,
  localparam int SLOT_SH   = $clog2(SLOT_BYTES),
  localparam int BANK_W    = $clog2(NBANKS),
  localparam int WORD_W    = ADDR_W - SLOT_SH,
  localparam int CNT_W     = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [LANES-1:0]        req_active,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  output logic                    gnt_valid,
  output logic [LANES-1:0]        gnt_mask,
  output logic                    done,
  output logic [CNT_W-1:0]        pass_count
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                    accept;
  logic [LANES-1:0]        pending, grant;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic                    write_q;
  logic [LANES*WORD_W-1:0] word_flat;
  logic [LANES*BANK_W-1:0] bank_flat;

  // request capture with explicit enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q  <= '0;
      write_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      write_q <= req_write;
    end
  end

  bcr_bank_map #(
    .LANES(LANES), .ADDR_W(ADDR_W), .SLOT_SH(SLOT_SH), .BANK_W(BANK_W)
  ) u_map (
    .addr_flat(addr_q), .word_flat(word_flat), .bank_flat(bank_flat)
  );

  bcr_pass_select #(
    .LANES(LANES), .WORD_W(WORD_W), .BANK_W(BANK_W)
  ) u_sel (
    .pending(pending), .is_write(write_q),
    .word_flat(word_flat), .bank_flat(bank_flat), .grant(grant)
  );

  bcr_pass_ctrl #(
    .LANES(LANES), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid),
    .req_active(req_active), .grant(grant), .accept(accept),
    .req_ready(req_ready), .pending(pending), .gnt_valid(gnt_valid),
    .done(done), .pass_count(pass_count)
  );

  assign gnt_mask = gnt_valid ? grant : '0;
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
  parameter int LANES = 32,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_active,
  input logic             gnt_valid,
  input logic [LANES-1:0] gnt_mask,
  input logic             done,
  input logic [CNT_W-1:0] pass_count
);
  logic [LANES-1:0] act_q, served_q;
  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= '0;
      served_q <= '0;
      seen_q   <= '0;
    end else if (req_valid && req_ready) begin
      act_q    <= req_active;
      served_q <= '0;
      seen_q   <= '0;
    end else if (gnt_valid) begin
      served_q <= served_q | gnt_mask;
      seen_q   <= seen_q + 1'b1;
    end
  end

  // R8
  grant_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> ((gnt_mask & ~act_q) == '0) && ((gnt_mask & served_q) == '0));
  // R8
  all_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && done) |-> ((served_q | gnt_mask) == act_q));
  // R9
  grant_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_mask != '0));
  // R10
  count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && done) |-> (pass_count == seen_q + 1'b1));
  // R2
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> !req_ready);
  // R11
  empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_active == '0) |=> (done && !gnt_valid && pass_count == '0));
endmodule

bind bank_conflict_resolver bcr_checker #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_active(req_active), .gnt_valid(gnt_valid), .gnt_mask(gnt_mask),
  .done(done), .pass_count(pass_count)
);

// File: tb/sim_bank_conflict_resolver.sv
`timescale 1ns/1ps
module sim_bank_conflict_resolver;
  localparam int L = 32;
  localparam int AW = 16;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write;
  logic [L-1:0]  req_active;
  logic [L*AW-1:0] req_addr;
  logic          gnt_valid, done;
  logic [L-1:0]  gnt_mask;
  logic [5:0]    pass_count;

  logic [AW-1:0] ba [L];
  int nvec, nfail;
  int cyc;

  bank_conflict_resolver u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_active(req_active), .req_addr(req_addr),
    .gnt_valid(gnt_valid), .gnt_mask(gnt_mask), .done(done), .pass_count(pass_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      nvec++; nfail++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference scheduler, written per bank from the requirements
  function automatic logic [L-1:0] model_pass(input logic [L-1:0] pend, input logic wr);
    logic [L-1:0] g;
    g = '0;
    for (int b = 0; b < 32; b++) begin
      int lead;
      lead = -1;
      for (int i = L - 1; i >= 0; i--)
        if (pend[i] && (((ba[i] >> 2) % 32) == b)) lead = i;
      if (lead >= 0) begin
        if (wr) g[lead] = 1'b1;
        else
          for (int i = 0; i < L; i++)
            if (pend[i] && ((ba[i] >> 2) == (ba[lead] >> 2))) g[i] = 1'b1;
      end
    end
    return g;
  endfunction

  task automatic run_req(input logic [L-1:0] act, input logic wr, output int np);
    logic [L-1:0] pend, eg;
    chk(req_ready == 1'b1, "R2 ready while idle", req_ready, 1);
    for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = ba[i];
    req_active = act; req_write = wr; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    pend = act; np = 0;
    if (act == '0) begin
      chk(done && !gnt_valid && pass_count == 0, "R11 empty request",
          {done, gnt_valid, pass_count}, {1'b1, 1'b0, 6'd0});
      @(posedge clk); @(negedge clk);
    end else begin
      while (pend != '0) begin
        eg = model_pass(pend, wr);
        pend = pend & ~eg;
        np++;
        chk(gnt_valid && gnt_mask == eg, wr ? "R7 write pass mask" : "R5 read pass mask",
            {gnt_valid, gnt_mask}, {1'b1, eg});
        chk(done == (pend == '0) && !req_ready, "R9/R10 done and ready in pass",
            {done, req_ready}, {(pend == '0), 1'b0});
        if (pend == '0)
          chk(pass_count == np, "R10 pass count", pass_count, np);
        @(posedge clk); @(negedge clk);
        if (eg == '0) break;
      end
    end
    chk(req_ready == 1'b1 && !gnt_valid, "R2 ready after done", {req_ready, gnt_valid}, 2'b10);
  endtask

  initial begin
    int np;
    void'($urandom(32'd4242));
    nvec = 0; nfail = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_active = '0; req_addr = '0;
    for (int i = 0; i < L; i++) ba[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !gnt_valid && !done, "R2 reset state",
        {req_ready, gnt_valid, done}, 3'b100);

    // R1: 70 and 198 share bank 17 (different slots) -> two read passes
    ba[0] = 16'd70; ba[1] = 16'd198;
    run_req(32'h3, 1'b0, np);
    chk(np == 2, "R1 addr 70/198 bank 17", np, 2);
    // R1: addresses 0 and 128 share bank 0
    ba[0] = 16'd0; ba[1] = 16'd128;
    run_req(32'h3, 1'b0, np);
    chk(np == 2, "R1 addr 0/128 bank 0", np, 2);

    // R3: distinct banks
    for (int i = 0; i < L; i++) ba[i] = 16'(4 * i + 1024);
    run_req('1, 1'b1, np);
    chk(np == 1, "R3 distinct banks write", np, 1);
    run_req('1, 1'b0, np);
    chk(np == 1, "R3 distinct banks read", np, 1);

    // R4: broadcast read of one slot
    for (int i = 0; i < L; i++) ba[i] = 16'd300 + 16'(i % 4);
    run_req('1, 1'b0, np);
    chk(np == 1, "R4 broadcast read", np, 1);
    // R7: same-slot writes serialize in lane order
    run_req('1, 1'b1, np);
    chk(np == 32, "R7 same-slot writes", np, 32);

    // R6: lane0 slot 40, lane1 slot 8, lane2 slot 40, all bank 8
    ba[0] = 16'd160; ba[1] = 16'd32; ba[2] = 16'd161;
    run_req(32'h7, 1'b0, np);
    chk(np == 2, "R6 lowest lane slot first", np, 2);

    // R8: inactive lanes conflicting with active ones are ignored
    for (int i = 0; i < L; i++) ba[i] = 16'd0 + 16'(128 * i);
    run_req(32'h0000_0100, 1'b0, np);
    chk(np == 1, "R8 inactive lanes ignored", np, 1);

    // R11: empty request
    run_req('0, 1'b0, np);
    chk(np == 0, "R11 zero passes", np, 0);

    // random mix
    for (int t = 0; t < 60; t++) begin
      logic [L-1:0] act;
      for (int i = 0; i < L; i++) ba[i] = 16'($urandom_range(0, (t % 3 == 0) ? 255 : 2047));
      act = $urandom();
      if (t % 5 == 0) act = '1;
      run_req(act, 1'($urandom_range(0, 1)), np);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule